// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer, nine bits wide by default, whose write side and read side each run on their own clock. The two clocks may be fully independent or driven from one source. Pointers cross between the domains in Gray code through two-flop synchronizers. Each flag is computed in the domain whose port it throttles. Empty and almost-empty are computed on the read side. Full, half-full and almost-full are computed on the write side.

Each port is qualified by two enables. On the write side, the second enable also selects where the data goes. When it is high, the word enters the buffer. When it is low, the word goes into two offset registers, one byte at a time in a fixed order. These registers set where the almost-empty and almost-full flags trip. The same byte sequence can be read back through the data output. An active-low output enable gates the read data, and a valid indication stands in for a high-impedance pin.

Top module: `dcf_fifo`

## Requirements
- R1: A word on `wr_data` is stored on each `wr_clk` rising edge at which `wr_gate_n` is 0, `wr_qual` is 1 and `flag_full` is 0. Stored words leave the buffer in the order they were written.
- R2: A read happens on a `rd_clk` rising edge at which `rd_gate_n` and `rd_qual_n` are both 0, the load select is high as seen in the read domain, and `flag_empty` is 0. That edge loads the oldest stored word into the output register.
- R3: A write attempted while `flag_full` is 1 is ignored. A read attempted while `flag_empty` is 1 is ignored. In both cases no pointer moves and the output register keeps its value.
- R4: `flag_empty` is 1 when the read-side count is zero. The read-side count uses the write pointer delayed by two `rd_clk` edges. With tied clocks, a word written at edge k clears `flag_empty` after edge k+2, and it can first be read at edge k+3.
- R5: `flag_full` is 1 when the write-side count equals DEPTH. `flag_half` is 1 when that count exceeds DEPTH/2. The write-side count uses the read pointer delayed by two `wr_clk` edges.
- R6: `flag_almost_full` is 1 when the write-side count plus the almost-full offset is at least DEPTH.
- R7: `flag_almost_empty` is 1 when the read-side count is at most the almost-empty offset.
- R8: A load happens on a `wr_clk` edge at which `wr_gate_n` is 0 and `wr_qual` is 0. Successive loads fill, in order: the almost-empty low byte (`wr_data[7:0]`), the almost-empty high part (`wr_data[HI_W-1:0]`, where HI_W is 1 at the default depth), the almost-full low byte, and the almost-full high part. The sequence then wraps.
- R9: A read-back happens on a `rd_clk` edge at which `wr_qual` is 0 (seen two read edges late) and both read enables are 0. It loads the next offset byte into the output register, zero-extended, in the same order as R8, and pops no data.
- R10: While `rd_oe_n` is 1, `rd_q` is all zeros and `rd_q_vld` is 0. While `rd_oe_n` is 0, `rd_q` shows the output register and `rd_q_vld` is 1.
- R11: The synchronous active-high `rst` clears both pointers, both sync chains and the output register. It sets `flag_empty` and `flag_almost_empty` to 1 and the other flags to 0. It restores both offsets to 7 and restarts both byte sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wr_gate_n | input | 1 | Write enable, active low |
| wr_qual | input | 1 | High: data write; low: offset load / read-back select |
| wr_data | input | WIDTH | Write data or offset byte |
| rd_gate_n | input | 1 | First read enable, active low |
| rd_qual_n | input | 1 | Second read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_q | output | WIDTH | Read data or offset byte, zero when disabled |
| rd_q_vld | output | 1 | High when `rd_q` is driven |
| flag_empty | output | 1 | Buffer empty (read domain) |
| flag_almost_empty | output | 1 | At or below the almost-empty offset (read domain) |
| flag_full | output | 1 | Buffer full (write domain) |
| flag_half | output | 1 | More than half full (write domain) |
| flag_almost_full | output | 1 | Within the almost-full offset of full (write domain) |

## Verification
The bound checker enforces, on every cycle, the properties that hold whatever the traffic:
- a blocked write or read leaves its pointer still;
- an accepted write advances the write pointer by exactly one;
- full implies half and almost-full, and empty implies almost-empty;
- the output enable gates the data;
- reset forces the flag values.

The bench's reference model covers what depends on history and timing. This includes the two-edge synchronizer lag on each flag, the exact cycle a first word becomes readable, word ordering across wrap-around, the load and read-back byte order with high parts set, and offsets returning to 7 after a mid-traffic reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int LO_W = 8;

    typedef enum logic [1:0] {
        STEP_AE_LO = 2'd0,
        STEP_AE_HI = 2'd1,
        STEP_AF_LO = 2'd2,
        STEP_AF_HI = 2'd3
    } step_t;

    typedef struct packed {
        logic full;
        logic half;
        logic almost_full;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic step_t next_step(input step_t s);
        return step_t'(2'(s + 2'd1));
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int DEPTH   = 64,
    parameter int PW      = 7,
    parameter int HI_W    = 1,
    parameter int OFF_W   = 9,
    parameter int DEF_OFF = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_n,
    input  logic             qual,
    input  logic [WIDTH-1:0] din,
    input  logic [PW-1:0]    rgray_sync,
    output logic             push,
    output logic [PW-1:0]    wbin,
    output logic [PW-1:0]    wgray,
    output logic [OFF_W-1:0] ae_off,
    output logic [OFF_W-1:0] af_off,
    output wr_flags_t        flags
);
    logic [PW-1:0] rbin_sync;
    logic [PW-1:0] count;
    logic          load;
    step_t         step;

    assign rbin_sync = PW'(gray_to_bin(32'(rgray_sync)));
    assign count     = wbin - rbin_sync;

    assign flags.full        = (32'(count) == 32'(DEPTH));
    assign flags.half        = (32'(count) >  32'(DEPTH / 2));
    assign flags.almost_full = (32'(count) + 32'(af_off) >= 32'(DEPTH));

    assign push = !gate_n &&  qual && !flags.full;
    assign load = !gate_n && !qual;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin + PW'(1);
            wgray <= PW'(bin_to_gray(32'(wbin + PW'(1))));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_off <= OFF_W'(DEF_OFF);
            af_off <= OFF_W'(DEF_OFF);
            step   <= STEP_AE_LO;
        end else if (load) begin
            case (step)
                STEP_AE_LO: ae_off[LO_W-1:0]     <= LO_W'(din);
                STEP_AE_HI: ae_off[OFF_W-1:LO_W] <= HI_W'(din);
                STEP_AF_LO: af_off[LO_W-1:0]     <= LO_W'(din);
                default:    af_off[OFF_W-1:LO_W] <= HI_W'(din);
            endcase
            step <= next_step(step);
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int PW    = 7,
    parameter int OFF_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_n,
    input  logic             qual_n,
    input  logic             oe_n,
    input  logic             ld_async,
    input  logic [PW-1:0]    wgray_sync,
    input  logic [WIDTH-1:0] mem_rdata,
    input  logic [OFF_W-1:0] ae_off,
    input  logic [OFF_W-1:0] af_off,
    output logic [PW-1:0]    rbin,
    output logic [PW-1:0]    rgray,
    output rd_flags_t        flags,
    output logic [WIDTH-1:0] q,
    output logic             q_vld
);
    logic [PW-1:0]    wbin_sync;
    logic [PW-1:0]    count;
    logic             ld_s;
    logic             go;
    logic             pop;
    logic             rb;
    logic [WIDTH-1:0] dout;
    logic [WIDTH-1:0] rb_byte;
    step_t            rb_step;

    dcf_sync #(.W(1), .RST_VAL(1'b1)) u_ld_sync (
        .clk (clk),
        .rst (rst),
        .d   (ld_async),
        .q   (ld_s)
    );

    assign wbin_sync = PW'(gray_to_bin(32'(wgray_sync)));
    assign count     = wbin_sync - rbin;

    assign flags.empty        = (count == '0);
    assign flags.almost_empty = (32'(count) <= 32'(ae_off));

    assign go  = !gate_n && !qual_n;
    assign pop = go &&  ld_s && !flags.empty;
    assign rb  = go && !ld_s;

    always_comb begin
        case (rb_step)
            STEP_AE_LO: rb_byte = WIDTH'(ae_off[LO_W-1:0]);
            STEP_AE_HI: rb_byte = WIDTH'(ae_off[OFF_W-1:LO_W]);
            STEP_AF_LO: rb_byte = WIDTH'(af_off[LO_W-1:0]);
            default:    rb_byte = WIDTH'(af_off[OFF_W-1:LO_W]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            dout    <= '0;
            rb_step <= STEP_AE_LO;
        end else if (pop) begin
            dout  <= mem_rdata;
            rbin  <= rbin + PW'(1);
            rgray <= PW'(bin_to_gray(32'(rbin + PW'(1))));
        end else if (rb) begin
            dout    <= rb_byte;
            rb_step <= next_step(rb_step);
        end
    end

    assign q     = oe_n ? '0 : dout;
    assign q_vld = !oe_n;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int DEPTH   = 64,
    parameter int DEF_OFF = 7
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst,
    input  logic             wr_gate_n,
    input  logic             wr_qual,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_gate_n,
    input  logic             rd_qual_n,
    input  logic             rd_oe_n,
    output logic [WIDTH-1:0] rd_q,
    output logic             rd_q_vld,
    output logic             flag_empty,
    output logic             flag_almost_empty,
    output logic             flag_full,
    output logic             flag_half,
    output logic             flag_almost_full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;
    localparam int HI_W  = (AW > LO_W) ? AW - LO_W : 1;
    localparam int OFF_W = LO_W + HI_W;

    logic [PW-1:0]    wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0]    wgray_at_rd, rgray_at_wr;
    logic [OFF_W-1:0] ae_off, af_off;
    logic [WIDTH-1:0] mem_rdata;
    logic             push;
    wr_flags_t        wflags;
    rd_flags_t        rflags;

    dcf_sync #(.W(PW)) u_w2r (
        .clk (rd_clk), .rst (rst), .d (wr_gray), .q (wgray_at_rd)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk (wr_clk), .rst (rst), .d (rd_gray), .q (rgray_at_wr)
    );

    dcf_wr_ctl #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW), .HI_W(HI_W),
        .OFF_W(OFF_W), .DEF_OFF(DEF_OFF)
    ) u_wr (
        .clk        (wr_clk),
        .rst        (rst),
        .gate_n     (wr_gate_n),
        .qual       (wr_qual),
        .din        (wr_data),
        .rgray_sync (rgray_at_wr),
        .push       (push),
        .wbin       (wr_bin),
        .wgray      (wr_gray),
        .ae_off     (ae_off),
        .af_off     (af_off),
        .flags      (wflags)
    );

    dcf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk  (wr_clk),
        .we    (push),
        .waddr (wr_bin[AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_bin[AW-1:0]),
        .rdata (mem_rdata)
    );

    dcf_rd_ctl #(.WIDTH(WIDTH), .PW(PW), .OFF_W(OFF_W)) u_rd (
        .clk        (rd_clk),
        .rst        (rst),
        .gate_n     (rd_gate_n),
        .qual_n     (rd_qual_n),
        .oe_n       (rd_oe_n),
        .ld_async   (wr_qual),
        .wgray_sync (wgray_at_rd),
        .mem_rdata  (mem_rdata),
        .ae_off     (ae_off),
        .af_off     (af_off),
        .rbin       (rd_bin),
        .rgray      (rd_gray),
        .flags      (rflags),
        .q          (rd_q),
        .q_vld      (rd_q_vld)
    );

    assign flag_full         = wflags.full;
    assign flag_half         = wflags.half;
    assign flag_almost_full  = wflags.almost_full;
    assign flag_empty        = rflags.empty;
    assign flag_almost_empty = rflags.almost_empty;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int WIDTH = 9,
    parameter int PW    = 7
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst,
    input logic             wr_gate_n,
    input logic             wr_qual,
    input logic             rd_oe_n,
    input logic [WIDTH-1:0] rd_q,
    input logic             rd_q_vld,
    input logic             flag_empty,
    input logic             flag_almost_empty,
    input logic             flag_full,
    input logic             flag_half,
    input logic             flag_almost_full,
    input logic [PW-1:0]    wr_bin,
    input logic [PW-1:0]    rd_bin
);
    // R1
    a_r1_write_advances: assert property (@(posedge wr_clk) disable iff (rst)
        (!wr_gate_n && wr_qual && !flag_full) |=> (wr_bin == PW'($past(wr_bin) + PW'(1))));

    // R3
    a_r3_full_write_ignored: assert property (@(posedge wr_clk) disable iff (rst)
        (flag_full && !wr_gate_n && wr_qual) |=> $stable(wr_bin));

    // R3
    a_r3_empty_read_ignored: assert property (@(posedge rd_clk) disable iff (rst)
        flag_empty |=> $stable(rd_bin));

    // R5
    a_r5_full_has_half: assert property (@(posedge wr_clk) disable iff (rst)
        flag_full |-> flag_half);

    // R6
    a_r6_full_has_almost: assert property (@(posedge wr_clk) disable iff (rst)
        flag_full |-> flag_almost_full);

    // R7
    a_r7_empty_has_almost: assert property (@(posedge rd_clk) disable iff (rst)
        flag_empty |-> flag_almost_empty);

    // R10
    a_r10_oe_gates_data: assert property (@(posedge rd_clk) disable iff (rst)
        rd_oe_n |-> (rd_q == '0 && !rd_q_vld));

    // R11
    a_r11_reset_rd_flags: assert property (@(posedge rd_clk)
        rst |=> (flag_empty && flag_almost_empty));

    // R11
    a_r11_reset_wr_flags: assert property (@(posedge wr_clk)
        rst |=> (!flag_full && !flag_half && !flag_almost_full));
endmodule

bind dcf_fifo dcf_fifo_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
    .wr_clk            (wr_clk),
    .rd_clk            (rd_clk),
    .rst               (rst),
    .wr_gate_n         (wr_gate_n),
    .wr_qual           (wr_qual),
    .rd_oe_n           (rd_oe_n),
    .rd_q              (rd_q),
    .rd_q_vld          (rd_q_vld),
    .flag_empty        (flag_empty),
    .flag_almost_empty (flag_almost_empty),
    .flag_full         (flag_full),
    .flag_half         (flag_half),
    .flag_almost_full  (flag_almost_full),
    .wr_bin            (wr_bin),
    .rd_bin            (rd_bin)
);

// File: tb/test_dcf_fifo.sv
`timescale 1ns/1ps
module test_dcf_fifo;
    localparam int WIDTH   = 9;
    localparam int DEPTH   = 64;
    localparam int HI_MASK = 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_gate_n = 1'b1;
    logic             wr_qual = 1'b1;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_gate_n = 1'b1;
    logic             rd_qual_n = 1'b1;
    logic             rd_oe_n = 1'b0;
    logic [WIDTH-1:0] rd_q;
    logic             rd_q_vld;
    logic             flag_empty, flag_almost_empty, flag_full, flag_half, flag_almost_full;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    bit    cmp_on   = 0;
    string cur_req  = "R11";

    always #2.5 clk = ~clk;

    dcf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_dcf_fifo (
        .wr_clk(clk), .rd_clk(clk), .rst(rst),
        .wr_gate_n(wr_gate_n), .wr_qual(wr_qual), .wr_data(wr_data),
        .rd_gate_n(rd_gate_n), .rd_qual_n(rd_qual_n), .rd_oe_n(rd_oe_n),
        .rd_q(rd_q), .rd_q_vld(rd_q_vld),
        .flag_empty(flag_empty), .flag_almost_empty(flag_almost_empty),
        .flag_full(flag_full), .flag_half(flag_half), .flag_almost_full(flag_almost_full)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [WIDTH-1:0] mq[$];
    int m_wc = 0, m_rc = 0, m_ws1 = 0, m_ws2 = 0, m_rs1 = 0, m_rs2 = 0;
    int m_ae = 7, m_af = 7, m_ldstep = 0, m_rbstep = 0, m_dout = 0;
    bit m_ld1 = 1, m_ld2 = 1;

    function automatic int rb_value(input int s, input int ae, input int af);
        case (s)
            0: return ae & 255;
            1: return ae >> 8;
            2: return af & 255;
            default: return af >> 8;
        endcase
    endfunction

    always @(posedge clk) begin
        int cw, cr, ecw, ecr, eq;
        bit full_p, empty_p, wr, ld, go, pop, rb;
        cw = m_wc - m_rs2;
        cr = m_ws2 - m_rc;
        full_p  = (cw == DEPTH);
        empty_p = (cr == 0);
        if (rst) begin
            mq.delete();
            m_wc = 0; m_rc = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
            m_ae = 7; m_af = 7; m_ldstep = 0; m_rbstep = 0; m_dout = 0;
            m_ld1 = 1; m_ld2 = 1;
            cmp_on = 1;
        end else begin
            wr  = !wr_gate_n && wr_qual && !full_p;
            ld  = !wr_gate_n && !wr_qual;
            go  = !rd_gate_n && !rd_qual_n;
            pop = go && m_ld2 && !empty_p;
            rb  = go && !m_ld2;
            m_ws2 = m_ws1; m_ws1 = m_wc;
            m_rs2 = m_rs1; m_rs1 = m_rc;
            m_ld2 = m_ld1; m_ld1 = wr_qual;
            if (pop) begin
                m_dout = int'(mq.pop_front());
                m_rc++;
            end else if (rb) begin
                m_dout = rb_value(m_rbstep, m_ae, m_af);
                m_rbstep = (m_rbstep + 1) % 4;
            end
            if (wr) begin
                mq.push_back(wr_data);
                m_wc++;
            end
            if (ld) begin
                case (m_ldstep)
                    0: m_ae = (m_ae & ~255) | (int'(wr_data) & 255);
                    1: m_ae = (m_ae & 255) | ((int'(wr_data) & HI_MASK) << 8);
                    2: m_af = (m_af & ~255) | (int'(wr_data) & 255);
                    default: m_af = (m_af & 255) | ((int'(wr_data) & HI_MASK) << 8);
                endcase
                m_ldstep = (m_ldstep + 1) % 4;
            end
        end
        #1;
        if (cmp_on) begin
            ecw = m_wc - m_rs2;
            ecr = m_ws2 - m_rc;
            eq  = rd_oe_n ? 0 : m_dout;
            check(flag_empty == (ecr == 0), "R4", "empty", flag_empty, ecr == 0);
            check(flag_almost_empty == (ecr <= m_ae), "R7", "almost_empty",
                  flag_almost_empty, ecr <= m_ae);
            check(flag_full == (ecw == DEPTH), "R5", "full", flag_full, ecw == DEPTH);
            check(flag_half == (ecw > DEPTH / 2), "R5", "half", flag_half, ecw > DEPTH / 2);
            check(flag_almost_full == (ecw + m_af >= DEPTH), "R6", "almost_full",
                  flag_almost_full, ecw + m_af >= DEPTH);
            check(int'(rd_q) == eq, cur_req, "rd_q", int'(rd_q), eq);
            check(rd_q_vld == !rd_oe_n, "R10", "rd_q_vld", rd_q_vld, !rd_oe_n);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle();
        wr_gate_n = 1; wr_qual = 1; rd_gate_n = 1; rd_qual_n = 1;
    endtask

    task automatic load4(input int b0, input int b1, input int b2, input int b3);
        int v[4];
        v = '{b0, b1, b2, b3};
        wr_gate_n = 0; wr_qual = 0;
        for (int i = 0; i < 4; i++) begin
            wr_data = WIDTH'(v[i]);
            tick();
        end
        wr_gate_n = 1;
    endtask

    task automatic readback4(input string req, input int e0, input int e1,
                             input int e2, input int e3);
        int v[4];
        v = '{e0, e1, e2, e3};
        cur_req = req;
        wr_gate_n = 1; wr_qual = 0;
        tick(3);
        rd_gate_n = 0; rd_qual_n = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(int'(rd_q) == v[i], req, "offset readback byte", int'(rd_q), v[i]);
        end
        idle();
        tick(3);
    endtask

    initial begin
        // R11: reset state
        tick(4);
        rst = 0;
        check(flag_empty == 1, "R11", "empty after reset", flag_empty, 1);
        check(flag_almost_empty == 1, "R11", "almost_empty after reset", flag_almost_empty, 1);
        check(flag_full == 0, "R11", "full after reset", flag_full, 0);
        check(flag_half == 0, "R11", "half after reset", flag_half, 0);
        check(flag_almost_full == 0, "R11", "almost_full after reset", flag_almost_full, 0);
        check(rd_q == 0, "R11", "rd_q after reset", int'(rd_q), 0);

        // R1: ordered transfer
        cur_req = "R1";
        wr_gate_n = 0;
        for (int i = 0; i < 10; i++) begin
            wr_data = WIDTH'(i * 3 + 1);
            tick();
        end
        idle(); tick(3);
        rd_gate_n = 0; rd_qual_n = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            check(int'(rd_q) == i * 3 + 1, "R1", "ordered word", int'(rd_q), i * 3 + 1);
        end
        idle(); tick(3);

        // R4: first-word latency with read held active
        cur_req = "R4";
        wr_data = 9'h1A5; wr_gate_n = 0;
        rd_gate_n = 0; rd_qual_n = 0;
        tick();
        wr_gate_n = 1;
        tick();
        check(flag_empty == 1, "R4", "empty one edge after write", flag_empty, 1);
        check(rd_q == 9'd28, "R4", "no early read", int'(rd_q), 28);
        tick();
        check(flag_empty == 0, "R4", "empty cleared two edges after write", flag_empty, 0);
        tick();
        check(rd_q == 9'h1A5, "R4", "first word next edge", int'(rd_q), 'h1A5);
        idle(); tick(3);

        // R3: overfill and overdrain
        cur_req = "R3";
        wr_gate_n = 0;
        for (int i = 0; i < 70; i++) begin
            wr_data = WIDTH'(i + 100);
            tick();
        end
        check(flag_full == 1, "R3", "full after overfill", flag_full, 1);
        idle(); tick(3);
        rd_gate_n = 0; rd_qual_n = 0;
        tick(72);
        check(rd_q == 9'd163, "R3", "last accepted word kept", int'(rd_q), 163);
        check(flag_empty == 1, "R3", "empty after overdrain", flag_empty, 1);
        idle(); tick(3);

        // R8/R9: load and read back, high parts set
        load4(9'h005, 9'h001, 9'h002, 9'h001);
        readback4("R8", 5, 1, 2, 1);
        load4(3, 0, 10, 0);
        readback4("R9", 3, 0, 10, 0);

        // R6/R7: flag thresholds with new offsets
        cur_req = "R6";
        wr_gate_n = 0;
        for (int i = 0; i < 60; i++) begin
            wr_data = WIDTH'(i);
            tick();
        end
        idle(); tick(3);
        check(flag_almost_full == 1, "R6", "almost_full at 60 with offset 10", flag_almost_full, 1);
        check(flag_almost_empty == 0, "R7", "almost_empty clear at 60", flag_almost_empty, 0);
        cur_req = "R7";
        rd_gate_n = 0; rd_qual_n = 0;
        tick(57);
        idle(); tick(3);
        check(flag_almost_empty == 1, "R7", "almost_empty at 3 words", flag_almost_empty, 1);
        rd_gate_n = 0; rd_qual_n = 0;
        tick(4);
        idle(); tick(3);

        // R10: output enable
        cur_req = "R10";
        rd_oe_n = 1;
        wr_gate_n = 0; wr_data = 9'h0F0;
        tick(2);
        wr_gate_n = 1; tick(3);
        rd_gate_n = 0; rd_qual_n = 0; tick();
        idle();
        check(rd_q == 0, "R10", "rd_q gated", int'(rd_q), 0);
        check(rd_q_vld == 0, "R10", "rd_q_vld low", rd_q_vld, 0);
        rd_oe_n = 0;
        tick();
        check(rd_q == 9'h0F0, "R10", "rd_q shown when enabled", int'(rd_q), 'h0F0);
        rd_gate_n = 0; rd_qual_n = 0; tick(2);
        idle(); tick(3);

        // R2: mixed concurrent traffic
        cur_req = "R2";
        rd_qual_n = 0;
        for (int i = 0; i < 300; i++) begin
            wr_gate_n = (i % 3 == 0);
            rd_gate_n = !(i % 5 < 3);
            wr_data = WIDTH'(i * 7);
            tick();
        end
        idle(); tick(3);

        // R11: reset in the middle of traffic restores offsets
        cur_req = "R11";
        wr_gate_n = 0;
        for (int i = 0; i < 20; i++) begin
            wr_data = WIDTH'(i);
            tick();
        end
        idle();
        rst = 1; tick(3); rst = 0;
        check(flag_empty == 1, "R11", "empty after mid reset", flag_empty, 1);
        check(flag_almost_full == 0, "R11", "almost_full after mid reset", flag_almost_full, 0);
        check(flag_half == 0, "R11", "half after mid reset", flag_half, 0);
        readback4("R11", 7, 0, 7, 0);

        tick(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule